// File: doc/BRIEF.md
# Floating-Point Operand Unpack and Classify

This block takes one raw operand of up to 128 bits together with a format code and turns it into the common unpacked form used by a floating-point datapath. That form has a sign, a signed unbiased exponent, a 128-bit mantissa with its leading one at a fixed bit, and a class code. The operand may be a 32-bit two's-complement integer or an IEEE single, double or quad value. The operand is always left-aligned in the 128-bit input, so its most significant 32-bit word sits in bits 127:96.

Subnormal and integer inputs are normalized by a leading-zero count and a barrel shift. Signalling NaNs are quieted on the way in and flagged. A single register stage with a valid/ready handshake sits between the combinational unpack and the outputs. Downstream arithmetic therefore sees one consistent alignment, whatever the source format was.

Top module: `fp_operand_unpack`

## Requirements
- R1: The output sign always equals operand bit 127, for every supported format, including integers and NaNs.
- R2: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. An IEEE input with a zero exponent field and a zero fraction, or an integer input of zero, yields class 0 with exponent 0 and mantissa 0.
- R3: An IEEE input with a zero exponent field and a nonzero fraction gets class 1 and starts at exponent 1 minus bias, with no implied one. It is then shifted left until bit 126 is set, and the exponent drops by the shift amount.
- R4: An all-ones exponent field with a zero fraction yields class 2, exponent 0 and mantissa 0.
- R5: An all-ones exponent field with a nonzero fraction is a NaN. Its fraction is placed with its top bit at mantissa bit 125, the exponent is 0, and when bit 125 is already set the class is 3 and out_invalid is low.
- R6: A NaN whose top fraction bit is clear is signalling. The block sets mantissa bit 125, reports class 4 and raises out_invalid. out_invalid is low for every other class.
- R7: A normal IEEE input gets class 1, an exponent equal to the biased field minus the bias (127, 1023 or 16383), mantissa bit 126 set, and its fraction directly below bit 126.
- R8: A nonzero integer is converted to its magnitude, with the most negative value giving 2^31. It starts at exponent 126 with the magnitude in the low 32 mantissa bits and is normalized so that bit 126 is set.
- R9: Format codes are 0 integer, 1 single, 2 double and 3 quad. Any code from 4 to 7 sets out_err for that result.
- R10: out_sticky is 0 on every result.
- R11: A result appears on the outputs one cycle after its operand is accepted. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the outputs hold. After reset, out_valid is 0.
- R12: For integer, single and double inputs, the operand bits below the format's width do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_fmt | input | 3 | Format code |
| in_op | input | 128 | Left-aligned raw operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Unsupported format code |
| out_sign | output | 1 | Sign of the value |
| out_class | output | 3 | Class code |
| out_exp | output | EXP_W | Signed unbiased exponent |
| out_mant | output | MANT_W | Mantissa, leading one at bit ONE_POS |
| out_sticky | output | 1 | Sticky bit, always clear |
| out_invalid | output | 1 | Signalling NaN seen |

## Verification
The bench aims at the following boundaries, and each one catches a specific kind of fault:
- The smallest subnormals of every format need the longest normalizing shift. A short barrel stage or a wrong exponent decrement gives a mantissa without bit 126 set, or an exponent that is off by a power of two.
- The most negative integer exposes a magnitude step that overflows.
- A NaN that differs from infinity only in its lowest fraction bit exposes a fraction-is-zero test that looks at too few bits.
- Quiet and signalling NaNs that differ only in the top fraction bit expose a design that forgets to set the quiet bit or mislabels the class.
- Random backpressure on the result side shows whether the output register changes or drops a result while it is stalled.

// File: rtl/fpu_unpack_pkg.sv
`timescale 1ns/1ps
package fpu_unpack_pkg;

   localparam int OP_W     = 128;
   localparam int INT_W    = 32;
   localparam int NUM_IEEE = 3;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NUM  = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } opclass_e;

   typedef enum logic [2:0] {
      FMT_INT  = 3'd0,
      FMT_SGL  = 3'd1,
      FMT_DBL  = 3'd2,
      FMT_QUAD = 3'd3
   } fmt_e;

   // index 0 = single, 1 = double, 2 = quad
   function automatic int ieee_exp_bits(input int idx);
      case (idx)
         0:       return 8;
         1:       return 11;
         default: return 15;
      endcase
   endfunction

   function automatic int ieee_frac_bits(input int idx);
      case (idx)
         0:       return 23;
         1:       return 52;
         default: return 112;
      endcase
   endfunction

   function automatic int ieee_bias(input int idx);
      return (1 << (ieee_exp_bits(idx) - 1)) - 1;
   endfunction

   localparam int MAX_FRAC_BITS = 112;
   localparam int MIN_EXP_W     = 16;

endpackage

// File: rtl/fup_ieee_fields.sv
`timescale 1ns/1ps
module fup_ieee_fields
   import fpu_unpack_pkg::*;
#(
   parameter int MANT_W  = 128,
   parameter int ONE_POS = 126,
   parameter int EXP_W   = 18,
   parameter int IDX     = 0
) (
   input  logic [OP_W-1:0]          op,
   output logic                     exp_zero,
   output logic                     exp_max,
   output logic                     frac_zero,
   output logic signed [EXP_W-1:0]  exp_unb,
   output logic [MANT_W-1:0]        frac_mant
);

   localparam int EB       = ieee_exp_bits(IDX);
   localparam int FB       = ieee_frac_bits(IDX);
   localparam int BIAS     = ieee_bias(IDX);
   localparam int FRAC_LSB = OP_W - 1 - EB - FB;
   localparam int ALIGN    = ONE_POS - FB;
   localparam int TOP_PAD  = MANT_W - ONE_POS;

   logic [EB-1:0]            bexp;
   logic [FB-1:0]            frac;
   logic signed [EXP_W-1:0]  bexp_s;

   assign bexp      = op[OP_W-2 -: EB];
   assign frac      = op[FRAC_LSB +: FB];
   assign exp_zero  = (bexp == '0);
   assign exp_max   = &bexp;
   assign frac_zero = (frac == '0);
   assign bexp_s    = $signed(EXP_W'(bexp));

   // subnormals take the minimum normal exponent; the normalizer then lowers it
   assign exp_unb   = exp_zero ? EXP_W'(1 - BIAS) : (bexp_s - EXP_W'(BIAS));

   // fraction sits directly below the fixed leading-one position
   assign frac_mant = {{TOP_PAD{1'b0}}, frac, {ALIGN{1'b0}}};

endmodule

// File: rtl/fup_lzc.sv
`timescale 1ns/1ps
module fup_lzc #(
   parameter int W     = 127,
   parameter int CHUNK = 16,
   localparam int CW   = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count,
   output logic          all_zero
);

   assign all_zero = ~|vec;

   if (CHUNK < 2) begin : g_bad_chunk
      $error("fup_lzc: CHUNK must be at least 2");
   end

   if (CHUNK >= W) begin : g_linear
      // one flat priority scan from the top bit
      always_comb begin
         logic seen;
         seen  = 1'b0;
         count = CW'(W);
         for (int i = W - 1; i >= 0; i--) begin
            if (!seen && vec[i]) begin
               seen  = 1'b1;
               count = CW'(W - 1 - i);
            end
         end
      end
   end else begin : g_chunked
      // two levels: a count within each chunk, then a priority pick over chunks
      localparam int NCH = (W + CHUNK - 1) / CHUNK;
      localparam int PW  = NCH * CHUNK;
      localparam int CLW = $clog2(CHUNK + 1);

      logic [PW-1:0]      padded;
      logic [NCH-1:0]     ch_nz;
      logic [NCH*CLW-1:0] ch_lz;

      assign padded = PW'(vec) << (PW - W);

      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         logic [CHUNK-1:0] seg;
         logic [CLW-1:0]   lz_loc;
         assign seg = padded[PW-1-c*CHUNK -: CHUNK];
         always_comb begin
            logic seen;
            seen   = 1'b0;
            lz_loc = CLW'(CHUNK);
            for (int i = CHUNK - 1; i >= 0; i--) begin
               if (!seen && seg[i]) begin
                  seen   = 1'b1;
                  lz_loc = CLW'(CHUNK - 1 - i);
               end
            end
         end
         assign ch_nz[c]               = |seg;
         assign ch_lz[c*CLW +: CLW]    = lz_loc;
      end

      always_comb begin
         logic seen;
         seen  = 1'b0;
         count = CW'(W);
         for (int c = 0; c < NCH; c++) begin
            if (!seen && ch_nz[c]) begin
               seen  = 1'b1;
               count = CW'(c * CHUNK) + CW'(ch_lz[c*CLW +: CLW]);
            end
         end
      end
   end

endmodule

// File: rtl/fup_normalize.sv
`timescale 1ns/1ps
module fup_normalize #(
   parameter int MANT_W    = 128,
   parameter int ONE_POS   = 126,
   parameter int EXP_W     = 18,
   parameter int LZC_CHUNK = 16
) (
   input  logic [MANT_W-1:0]        mant_in,
   input  logic signed [EXP_W-1:0]  exp_in,
   output logic [MANT_W-1:0]        mant_out,
   output logic signed [EXP_W-1:0]  exp_out
);

   localparam int SCAN_W = ONE_POS + 1;
   localparam int SH_W   = $clog2(SCAN_W + 1);

   logic [SH_W-1:0]   lz;
   logic              none;
   logic [SH_W-1:0]   shamt;
   logic [MANT_W-1:0] stage [SH_W+1];

   fup_lzc #(
      .W     (SCAN_W),
      .CHUNK (LZC_CHUNK)
   ) i_lzc (
      .vec      (mant_in[ONE_POS:0]),
      .count    (lz),
      .all_zero (none)
   );

   assign shamt    = none ? '0 : lz;
   assign stage[0] = mant_in;

   // logarithmic barrel shifter, one stage per shift-amount bit
   for (genvar k = 0; k < SH_W; k++) begin : g_shift
      assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
   end

   assign mant_out = stage[SH_W];
   assign exp_out  = exp_in - $signed(EXP_W'(shamt));

endmodule

// File: rtl/fp_operand_unpack.sv
`timescale 1ns/1ps
module fp_operand_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int MANT_W    = 128,
   parameter int ONE_POS   = 126,
   parameter int EXP_W     = 18,
   parameter int LZC_CHUNK = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [2:0]               in_fmt,
   input  logic [127:0]             in_op,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic                     out_err,
   output logic                     out_sign,
   output logic [2:0]               out_class,
   output logic signed [EXP_W-1:0]  out_exp,
   output logic [MANT_W-1:0]        out_mant,
   output logic                     out_sticky,
   output logic                     out_invalid
);

   localparam int QBIT = ONE_POS - 1;

   // elaboration-time parameter checks
   if (ONE_POS >= MANT_W) begin : g_chk_pos
      $error("fp_operand_unpack: ONE_POS must lie inside the mantissa");
   end
   if (ONE_POS < MAX_FRAC_BITS + 1 || ONE_POS < INT_W) begin : g_chk_room
      $error("fp_operand_unpack: ONE_POS leaves no room for the widest fraction");
   end
   if (EXP_W < MIN_EXP_W) begin : g_chk_exp
      $error("fp_operand_unpack: EXP_W too narrow for quad subnormals");
   end

   // ---------------- per-format field extraction ----------------
   logic                    f_ez [NUM_IEEE];
   logic                    f_em [NUM_IEEE];
   logic                    f_fz [NUM_IEEE];
   logic signed [EXP_W-1:0] f_exp [NUM_IEEE];
   logic [MANT_W-1:0]       f_mant [NUM_IEEE];

   for (genvar g = 0; g < NUM_IEEE; g++) begin : g_fmt
      fup_ieee_fields #(
         .MANT_W  (MANT_W),
         .ONE_POS (ONE_POS),
         .EXP_W   (EXP_W),
         .IDX     (g)
      ) i_fields (
         .op        (in_op),
         .exp_zero  (f_ez[g]),
         .exp_max   (f_em[g]),
         .frac_zero (f_fz[g]),
         .exp_unb   (f_exp[g]),
         .frac_mant (f_mant[g])
      );
   end

   // ---------------- integer path ----------------
   logic [INT_W-1:0]        int_word;
   logic [INT_W-1:0]        int_mag;
   assign int_word = in_op[OP_W-1 -: INT_W];
   assign int_mag  = int_word[INT_W-1] ? (~int_word + 1'b1) : int_word;

   // ---------------- classification and pre-normal selection ----------------
   opclass_e                cls;
   logic                    fmt_bad;
   logic [MANT_W-1:0]       pre_mant;
   logic signed [EXP_W-1:0] pre_exp;
   logic [MANT_W-1:0]       nan_mant;

   always_comb begin
      logic                    is_ieee;
      int                      sel;
      logic                    s_ez, s_em, s_fz;
      logic signed [EXP_W-1:0] s_exp;
      logic [MANT_W-1:0]       s_mant;

      is_ieee  = 1'b0;
      sel      = 0;
      fmt_bad  = 1'b0;
      cls      = CLS_ZERO;
      pre_mant = '0;
      pre_exp  = '0;
      nan_mant = '0;

      case (in_fmt)
         FMT_INT: begin
            if (int_word != '0) begin
               cls      = CLS_NUM;
               pre_mant = MANT_W'(int_mag);
               pre_exp  = EXP_W'(ONE_POS);
            end
         end
         FMT_SGL:  begin is_ieee = 1'b1; sel = 0; end
         FMT_DBL:  begin is_ieee = 1'b1; sel = 1; end
         FMT_QUAD: begin is_ieee = 1'b1; sel = 2; end
         default:  fmt_bad = 1'b1;
      endcase

      s_ez   = 1'b0;
      s_em   = 1'b0;
      s_fz   = 1'b1;
      s_exp  = '0;
      s_mant = '0;
      for (int g = 0; g < NUM_IEEE; g++) begin
         if (sel == g) begin
            s_ez   = f_ez[g];
            s_em   = f_em[g];
            s_fz   = f_fz[g];
            s_exp  = f_exp[g];
            s_mant = f_mant[g];
         end
      end

      if (is_ieee) begin
         if (s_ez) begin
            if (!s_fz) begin
               cls      = CLS_NUM;
               pre_mant = s_mant;
               pre_exp  = s_exp;
            end
         end else if (s_em) begin
            if (s_fz) begin
               cls = CLS_INF;
            end else begin
               nan_mant       = s_mant;
               cls            = s_mant[QBIT] ? CLS_QNAN : CLS_SNAN;
               nan_mant[QBIT] = 1'b1;
            end
         end else begin
            cls               = CLS_NUM;
            pre_mant          = s_mant;
            pre_mant[ONE_POS] = 1'b1;
            pre_exp           = s_exp;
         end
      end
   end

   // ---------------- normalization ----------------
   logic [MANT_W-1:0]       norm_mant;
   logic signed [EXP_W-1:0] norm_exp;

   fup_normalize #(
      .MANT_W    (MANT_W),
      .ONE_POS   (ONE_POS),
      .EXP_W     (EXP_W),
      .LZC_CHUNK (LZC_CHUNK)
   ) i_norm (
      .mant_in  (pre_mant),
      .exp_in   (pre_exp),
      .mant_out (norm_mant),
      .exp_out  (norm_exp)
   );

   logic [MANT_W-1:0]       res_mant;
   logic signed [EXP_W-1:0] res_exp;

   always_comb begin
      res_mant = '0;
      res_exp  = '0;
      if (cls == CLS_NUM) begin
         res_mant = norm_mant;
         res_exp  = norm_exp;
      end else if (cls == CLS_QNAN || cls == CLS_SNAN) begin
         res_mant = nan_mant;
      end
   end

   // ---------------- output register with handshake ----------------
   logic accept;
   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_err     <= 1'b0;
         out_sign    <= 1'b0;
         out_class   <= CLS_ZERO;
         out_exp     <= '0;
         out_mant    <= '0;
         out_sticky  <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         if (in_ready) begin
            out_valid <= in_valid;
         end
         if (accept) begin
            out_err     <= fmt_bad;
            out_sign    <= in_op[OP_W-1];
            out_class   <= cls;
            out_exp     <= res_exp;
            out_mant    <= res_mant;
            out_sticky  <= 1'b0;
            out_invalid <= (cls == CLS_SNAN);
         end
      end
   end

   // ---------------- assertions ----------------
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
                                  && $stable(out_class) && $stable(out_sign));

   p_valid_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   p_num_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_class == CLS_NUM |-> out_mant[ONE_POS]);

   p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && (out_class == CLS_QNAN || out_class == CLS_SNAN)
         |-> out_mant[QBIT] && out_exp == '0);

   p_zero_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && (out_class == CLS_ZERO || out_class == CLS_INF)
         |-> out_mant == '0 && out_exp == '0);

   p_invalid_only_snan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err && out_invalid |-> out_class == CLS_SNAN);

   p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_sign == $past(in_op[OP_W-1]));

endmodule

// File: tb/test_fp_operand_unpack.sv
`timescale 1ns/1ps
module test_fp_operand_unpack;

   typedef struct {
      logic         err;
      logic         sign;
      logic [2:0]   cls;
      logic [17:0]  exp;
      logic [127:0] mant;
      logic         inv;
      string        tag;
   } exp_t;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [2:0]          in_fmt = 3'd0;
   logic [127:0]        in_op = '0;
   logic                out_valid;
   logic                out_ready = 1'b1;
   logic                out_err;
   logic                out_sign;
   logic [2:0]          out_class;
   logic signed [17:0]  out_exp;
   logic [127:0]        out_mant;
   logic                out_sticky;
   logic                out_invalid;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   bit   stall_en = 1'b0;
   exp_t sb [$];

   always #2.5 clk = ~clk;

   fp_operand_unpack i_fp_operand_unpack (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_fmt      (in_fmt),
      .in_op       (in_op),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_err     (out_err),
      .out_sign    (out_sign),
      .out_class   (out_class),
      .out_exp     (out_exp),
      .out_mant    (out_mant),
      .out_sticky  (out_sticky),
      .out_invalid (out_invalid)
   );

   // expected result from the requirements
   function automatic exp_t ref_model(input logic [2:0] f, input logic [127:0] op, input string tag);
      exp_t         r;
      int           eb, fb, bias, e;
      logic [127:0] m, fr;
      logic [31:0]  w;
      logic [14:0]  ex;
      r.err = 1'b0; r.sign = op[127]; r.cls = 3'd0; r.exp = '0; r.mant = '0; r.inv = 1'b0; r.tag = tag;
      if (f > 3'd3) begin
         r.err = 1'b1;
         return r;
      end
      if (f == 3'd0) begin
         w = op[127:96];
         if (w != 0) begin
            if (w[31]) w = -w;
            m = {96'b0, w};
            e = 126;
            while (!m[126]) begin m = m << 1; e--; end
            r.cls = 3'd1; r.mant = m; r.exp = 18'(e);
         end
         return r;
      end
      eb   = (f == 3'd1) ? 8  : (f == 3'd2) ? 11 : 15;
      fb   = (f == 3'd1) ? 23 : (f == 3'd2) ? 52 : 112;
      bias = (1 << (eb - 1)) - 1;
      ex   = 15'((op >> (127 - eb)) & ((128'd1 << eb) - 1));
      fr   = (op >> (127 - eb - fb)) & ((128'd1 << fb) - 1);
      fr   = fr << (126 - fb);
      if (ex == 0) begin
         if (fr != 0) begin
            m = fr; e = 1 - bias;
            while (!m[126]) begin m = m << 1; e--; end
            r.cls = 3'd1; r.mant = m; r.exp = 18'(e);
         end
      end else if (int'(ex) == (1 << eb) - 1) begin
         if (fr == 0) begin
            r.cls = 3'd2;
         end else begin
            r.mant = fr;
            if (!fr[125]) begin r.mant[125] = 1'b1; r.cls = 3'd4; r.inv = 1'b1; end
            else r.cls = 3'd3;
         end
      end else begin
         r.cls  = 3'd1;
         r.exp  = 18'(int'(ex) - bias);
         r.mant = fr | (128'd1 << 126);
      end
      return r;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic send(input logic [2:0] f, input logic [127:0] op, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_fmt = f; in_op = op;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      sb.push_back(ref_model(f, op, tag));
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [127:0] sgl(input logic [31:0] v);
      return {v, 96'h0};
   endfunction
   function automatic logic [127:0] dbl(input logic [63:0] v);
      return {v, 64'h0};
   endfunction

   // result-side readiness
   initial begin
      forever begin
         @(negedge clk);
         out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   // monitor / scoreboard
   initial begin
      logic         stalled;
      logic [127:0] pm;
      logic [17:0]  pe;
      logic [2:0]   pc;
      logic         ps;
      exp_t         x;
      stalled = 1'b0; pm = '0; pe = '0; pc = '0; ps = 1'b0;
      forever begin
         @(negedge clk);
         #1;
         if (stalled) begin
            checks++;
            if (!(out_valid && out_mant == pm && out_exp == pe && out_class == pc && out_sign == ps)) begin
               errors++;
               $display("FAIL R11 hold under stall: valid=%0d class=%0d exp=%0h, expected valid=1 class=%0d exp=%0h",
                        out_valid, out_class, out_exp, pc, pe);
            end
         end
         stalled = out_valid && !out_ready;
         pm = out_mant; pe = out_exp; pc = out_class; ps = out_sign;
         if (out_valid && out_ready) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R11 unexpected result: class=%0d, expected no output", out_class);
            end else begin
               x = sb.pop_front();
               if (x.err) begin
                  if (out_err !== 1'b1) begin
                     errors++;
                     $display("FAIL %s err: got %0d expected 1", x.tag, out_err);
                  end
               end else if (out_err !== 1'b0 || out_sign !== x.sign || out_class !== x.cls ||
                            out_exp !== x.exp || out_mant !== x.mant || out_invalid !== x.inv ||
                            out_sticky !== 1'b0) begin
                  errors++;
                  $display("FAIL %s: got err=%0d sign=%0d cls=%0d exp=%h mant=%h inv=%0d sticky=%0d, expected err=0 sign=%0d cls=%0d exp=%h mant=%h inv=%0d sticky=0",
                           x.tag, out_err, out_sign, out_class, out_exp, out_mant, out_invalid, out_sticky,
                           x.sign, x.cls, x.exp, x.mant, x.inv);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   // stimulus
   initial begin
      repeat (3) @(negedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R11 reset state: out_valid=%0d in_ready=%0d, expected 0 and 1", out_valid, in_ready);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R11 one-cycle latency
      send(3'd1, sgl(32'h3F80_0000), "R7");
      idle();
      #1;
      checks++;
      if (out_valid !== 1'b1) begin
         errors++;
         $display("FAIL R11 latency: out_valid=%0d one cycle after accept, expected 1", out_valid);
      end

      // R1 / R7 normals
      send(3'd1, sgl(32'hC020_0000), "R1");
      send(3'd1, sgl(32'h7F7F_FFFF), "R7");
      send(3'd2, dbl(64'h3FF0_0000_0000_0000), "R7");
      send(3'd2, dbl(64'hC009_21FB_5444_2D18), "R1");
      send(3'd3, {64'h3FFF_0000_0000_0000, 64'h0}, "R7");
      send(3'd3, {64'hBFFF_8000_0000_0000, 64'h1}, "R1");
      // R12 ignored low bits
      send(3'd1, {32'h3F80_0000, 96'hDEAD_BEEF_0123_4567_89AB_CDEF}, "R12");
      send(3'd2, {64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}, "R12");
      send(3'd0, {32'h0000_3039, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF}, "R12");
      // R2 zeros
      send(3'd1, sgl(32'h0000_0000), "R2");
      send(3'd1, sgl(32'h8000_0000), "R2");
      send(3'd3, 128'h8000_0000_0000_0000_0000_0000_0000_0000, "R2");
      send(3'd0, 128'h0, "R2");
      // R3 subnormals
      send(3'd1, sgl(32'h0000_0001), "R3");
      send(3'd1, sgl(32'h0040_0000), "R3");
      send(3'd2, dbl(64'h8000_0000_0000_0001), "R3");
      send(3'd3, 128'h1, "R3");
      send(3'd3, 128'h0000_8000_0000_0000_0000_0000_0000_0000, "R3");
      // R4 infinities
      send(3'd1, sgl(32'h7F80_0000), "R4");
      send(3'd2, dbl(64'hFFF0_0000_0000_0000), "R4");
      send(3'd3, 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, "R4");
      // R5 quiet NaNs
      send(3'd1, sgl(32'h7FC0_0001), "R5");
      send(3'd3, 128'hFFFF_8000_0000_0000_0000_0000_0000_0000, "R5");
      // R6 signalling NaNs
      send(3'd1, sgl(32'h7F80_0001), "R6");
      send(3'd2, dbl(64'h7FF0_0000_0000_0001), "R6");
      send(3'd3, 128'h7FFF_0000_0000_0000_0000_0000_0000_0001, "R6");
      // R8 integers
      send(3'd0, {32'h0000_0001, 96'h0}, "R8");
      send(3'd0, {32'hFFFF_FFFF, 96'h0}, "R8");
      send(3'd0, {32'h8000_0000, 96'h0}, "R8");
      send(3'd0, {32'h7FFF_FFFF, 96'h0}, "R8");
      // R9 unsupported codes
      send(3'd4, sgl(32'h3F80_0000), "R9");
      send(3'd7, sgl(32'h3F80_0000), "R9");
      send(3'd5, 128'h0, "R9");

      // R10 / R11 random traffic under backpressure
      stall_en = 1'b1;
      for (int n = 0; n < 60; n++) begin
         logic [127:0] rop;
         rop = {$urandom, $urandom, $urandom, $urandom};
         if (n % 5 == 0) rop[126:112] = 15'h0;
         send(3'($urandom_range(0, 3)), rop, "R10");
      end
      idle();
      stall_en = 1'b0;

      for (int w = 0; w < 200 && sb.size() != 0; w++) @(negedge clk);
      #2;
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R11 drain: %0d results missing, expected 0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule